// File: doc/BRIEF.md
# Soft-Start Limited PWM Generator

This block produces the gate signal for the high-side switches of a three-phase brushless motor drive. A free-running carrier counter sets the switching period. The default length suits a carrier of about 25 kHz, and a different period length moves it anywhere in the 15 to 25 kHz band. The output is high while the counter is below the applied duty. A supervisor updates the duty command from time to time, and the block follows that command with three limits.

The applied duty may rise only in small steps, one step for each commutation strobe from the Hall decoder. A jump in the throttle therefore turns into a torque ramp over several electrical cycles. A drop in the command takes effect at once. The applied duty never goes above a ceiling set below the full period, so every period keeps a low interval that refreshes the bootstrap supply of the high-side driver.

A current-limit comparator input ends the present pulse at once. The output then stays low until the next carrier period begins, when it tries again. Removing the enable turns the output off and clears the applied duty, so every restart begins with a soft start.

Top module: `ssp_pwm_top`

## Requirements
- R1: The carrier repeats every PERIOD clock cycles. Within a period, `pwm_out` is high for exactly as many cycles as the applied duty D. The output is registered: it is high in the cycle after the counter value k satisfies k < D.
- R2: The target duty is the smaller of `duty_cmd` and CEIL, where CEIL is less than PERIOD. The applied duty never goes above CEIL, even when the command is larger.
- R3: The applied duty rises only in a cycle where `hall_evt` is high. Each such cycle raises it by STEP, or to the target if the target is closer. When `hall_evt` is low, a larger command does not change the duty.
- R4: When the target is below the applied duty, the applied duty takes the target value in the next cycle, whether or not `hall_evt` is high.
- R5: A high `ilim` sampled at a clock edge makes `pwm_out` low after that edge. The output stays low for the rest of that carrier period, even after `ilim` falls, and pulses again from the next period start.
- R6: A low `en` makes `pwm_out` low after the next edge and sets the applied duty to zero. After `en` returns high, the duty climbs again from zero by the rule in R3.
- R7: While `rst_n` is low, and until the reset release has passed through the two-stage synchronizer, `pwm_out` is low and the applied duty is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Drive enable. Low forces the output off and clears the duty |
| duty_cmd | input | CNT_W | Commanded duty in carrier ticks |
| hall_evt | input | 1 | One-cycle strobe on each Hall commutation |
| ilim | input | 1 | Current-limit comparator output, active high |
| pwm_out | output | 1 | High-side PWM gate signal |

## Verification
The assertions assume that `hall_evt` is a synchronous strobe and that `duty_cmd` and `ilim` are stable around the clock edge. They also assume that the configuration keeps CEIL below PERIOD, so a pulse can never run across a period boundary. The stimulus changes every input only on the falling clock edge and gives each Hall strobe as a single-cycle pulse. It uses a short carrier with a ceiling below the period. Before a full-period count of high cycles begins, the bench waits for the applied duty to settle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Smaller of two unsigned tick values
  function automatic int unsigned ssp_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Width that holds 0 .. n-1, never below one bit
  function automatic int unsigned ssp_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ssp_rst_sync.sv
module ssp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ssp_carrier.sv
module ssp_carrier #(
  parameter int unsigned PERIOD = 8000,
  parameter int unsigned CNT_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/ssp_duty_ramp.sv
module ssp_duty_ramp #(
  parameter int unsigned CEIL  = 7200,
  parameter int unsigned STEP  = 80,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hall_evt,
  input  logic [CNT_W-1:0] duty_cmd,
  output logic [CNT_W-1:0] duty_app
);

  localparam logic [CNT_W-1:0] CEIL_T = CNT_W'(CEIL);
  localparam logic [CNT_W:0]   STEP_T = (CNT_W+1)'(STEP);

  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] duty_d;
  logic             duty_we;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   stepped;
  logic             go_down;
  logic             go_up;

  always_comb begin
    target  = (duty_cmd > CEIL_T) ? CEIL_T : duty_cmd;
    stepped = {1'b0, duty_q} + STEP_T;
    go_down = (target < duty_q);
    go_up   = hall_evt && (target > duty_q);
    duty_we = !en || go_down || go_up;
    if (!en) begin
      duty_d = '0;
    end else if (go_down) begin
      duty_d = target;
    end else if (go_up) begin
      duty_d = (stepped > {1'b0, target}) ? target : stepped[CNT_W-1:0];
    end else begin
      duty_d = duty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_we) duty_q <= duty_d;
  end

  assign duty_app = duty_q;

endmodule

// File: rtl/ssp_gate.sv
module ssp_gate #(
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ilim,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_app,
  output logic             pwm_out
);

  logic trip_q;
  logic trip_d;
  logic pwm_q;
  logic pwm_d;

  always_comb begin
    // Latch a trip for the rest of the period; the wrap cycle clears it
    trip_d = en && (ilim || (trip_q && !wrap));
    pwm_d  = en && !ilim && !trip_q && (cnt < duty_app);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      pwm_q  <= pwm_d;
    end
  end

  assign pwm_out = pwm_q;

endmodule

// File: rtl/ssp_pwm_top.sv
module ssp_pwm_top #(
  parameter int unsigned PERIOD = 8000,
  parameter int unsigned CEIL   = 7200,
  parameter int unsigned STEP   = 80,
  parameter int unsigned CNT_W  = ssp_pkg::ssp_width(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             hall_evt,
  input  logic             ilim,
  output logic             pwm_out
);

  localparam int unsigned CEIL_EFF = ssp_pkg::ssp_min(CEIL, PERIOD - 1);

  logic             rst_n_i;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic [CNT_W-1:0] duty_app;

  ssp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ssp_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_car (
    .clk   (clk),
    .rst_n (rst_n_i),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  ssp_duty_ramp #(.CEIL(CEIL_EFF), .STEP(STEP), .CNT_W(CNT_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .en       (en),
    .hall_evt (hall_evt),
    .duty_cmd (duty_cmd),
    .duty_app (duty_app)
  );

  ssp_gate #(.CNT_W(CNT_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .en       (en),
    .ilim     (ilim),
    .wrap     (wrap),
    .cnt      (cnt),
    .duty_app (duty_app),
    .pwm_out  (pwm_out)
  );

endmodule

// File: rtl/ssp_pwm_chk.sv
module ssp_pwm_chk #(
  parameter int unsigned PERIOD = 8000,
  parameter int unsigned CEIL   = 7200,
  parameter int unsigned STEP   = 80,
  parameter int unsigned CNT_W  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             hall_evt,
  input logic             ilim,
  input logic             pwm_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] duty_app
);

  // Length of the current high run of the output
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (pwm_out) run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
    else              run_q <= '0;
  end

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < int'(PERIOD));

  a_r1_run_le_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= int'(CEIL));

  a_r2_duty_le_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    int'(duty_app) <= int'(CEIL));

  a_r3_rise_needs_hall: assert property (@(posedge clk) disable iff (!rst_n)
    !hall_evt |=> duty_app <= $past(duty_app));

  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hall_evt |=> int'(duty_app) <= int'($past(duty_app)) + int'(STEP));

  a_r5_ilim_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    ilim |=> !pwm_out);

  a_r6_en_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);

  a_r6_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> duty_app == '0);

endmodule

bind ssp_pwm_top ssp_pwm_chk #(
  .PERIOD (PERIOD),
  .CEIL   (CEIL_EFF),
  .STEP   (STEP),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .hall_evt (hall_evt),
  .ilim     (ilim),
  .pwm_out  (pwm_out),
  .cnt      (cnt),
  .duty_app (duty_app)
);

// File: tb/sim_ssp_pwm_top.sv
`timescale 1ns/1ps
module sim_ssp_pwm_top;

  localparam int unsigned PERIOD = 20;
  localparam int unsigned CEIL   = 18;
  localparam int unsigned STEP   = 2;
  localparam int unsigned CNT_W  = 5;
  localparam int NVEC = 10;

  // Each entry: {command[23:16], hall strobes[15:8], expected duty[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd10, 8'd0, 8'd0},   // R3 no strobe, no rise
    {8'd10, 8'd1, 8'd2},   // R3 one step
    {8'd10, 8'd3, 8'd8},   // R3 three steps
    {8'd10, 8'd2, 8'd10},  // R3 stops at target
    {8'd20, 8'd5, 8'd18},  // R2 ceiling
    {8'd20, 8'd3, 8'd18},  // R2 stays at ceiling
    {8'd4,  8'd0, 8'd4},   // R4 immediate drop
    {8'd7,  8'd1, 8'd6},   // R3 full step
    {8'd7,  8'd1, 8'd7},   // R3 partial step
    {8'd0,  8'd0, 8'd0}    // R4 drop to zero
  };

  logic             clk;
  logic             rst_n;
  logic             en;
  logic [CNT_W-1:0] duty_cmd;
  logic             hall_evt;
  logic             ilim;
  logic             pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ssp_pwm_top #(.PERIOD(PERIOD), .CEIL(CEIL), .STEP(STEP), .CNT_W(CNT_W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .duty_cmd (duty_cmd),
    .hall_evt (hall_evt),
    .ilim     (ilim),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hall_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      hall_evt = 1'b1;
      @(negedge clk);
      hall_evt = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int hi;
    rst_n = 1'b0; en = 1'b1; duty_cmd = 5'd10; hall_evt = 1'b0; ilim = 1'b0;
    repeat (4) @(negedge clk);
    // R7 output off while reset held
    chk("R7 reset output", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    count_high(PERIOD, hi);
    chk("R7 duty zero after reset", hi, 0);

    // Table walk: R1 count of high cycles per period equals the applied duty
    for (int v = 0; v < NVEC; v++) begin
      duty_cmd = CNT_W'(VEC[v][23:16]);
      @(negedge clk);
      hall_pulses(int'(VEC[v][15:8]));
      @(negedge clk);
      count_high(PERIOD, hi);
      chk($sformatf("R1 R2 R3 R4 vector %0d", v), hi, int'(VEC[v][7:0]));
    end

    // Build duty back up to 10
    duty_cmd = 5'd10;
    hall_pulses(5);
    count_high(PERIOD, hi);
    chk("R1 duty 10", hi, 10);

    // R6 disable forces off and clears duty
    en = 1'b0;
    @(negedge clk);
    chk("R6 output off after disable", int'(pwm_out), 0);
    count_high(PERIOD, hi);
    chk("R6 no pulses while disabled", hi, 0);
    en = 1'b1;
    @(negedge clk);
    count_high(PERIOD, hi);
    chk("R6 duty restarts from zero", hi, 0);
    hall_pulses(1);
    count_high(PERIOD, hi);
    chk("R6 ramp after re-enable", hi, 2);
    hall_pulses(4);
    count_high(PERIOD, hi);
    chk("R1 back at 10", hi, 10);

    // R5 single-cycle trip mid pulse
    begin
      logic prev;
      prev = pwm_out;
      @(negedge clk);
      while (!(pwm_out && !prev)) begin
        prev = pwm_out;
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    ilim = 1'b1;
    @(negedge clk);
    ilim = 1'b0;
    chk("R5 trip ends pulse", int'(pwm_out), 0);
    count_high(12, hi);
    chk("R5 held low rest of period", hi, 0);
    count_high(PERIOD, hi);
    chk("R5 retry next period", hi, 10);

    // R5 trip held across whole periods
    ilim = 1'b1;
    @(negedge clk);
    count_high(2 * PERIOD, hi);
    chk("R5 no pulse while limit high", hi, 0);
    ilim = 1'b0;
    @(negedge clk);
    count_high(2 * PERIOD, hi);
    chk("R5 pulses resume", hi, 20);

    // R3 command raise without strobe has no effect
    duty_cmd = 5'd16;
    @(negedge clk);
    count_high(PERIOD, hi);
    chk("R3 no rise without strobe", hi, 10);

    // R4 drop while a strobe is present
    duty_cmd = 5'd3;
    hall_evt = 1'b1;
    @(negedge clk);
    hall_evt = 1'b0;
    @(negedge clk);
    count_high(PERIOD, hi);
    chk("R4 drop with strobe", hi, 3);

    finish_run();
  end

endmodule